// File: doc/BRIEF.md
# Stale-Flag Zeroing Memory Wrapper

This block wraps a synchronous single-port RAM, whose storage has no reset, and adds a clear-all command that takes effect in one clock cycle. Next to the RAM sits one flag register per entry. A set flag means the entry is stale. Reads of a stale entry return zero in place of whatever the RAM holds. A write to an entry makes it fresh again. The clear command sets every flag at once, so no sweep through the addresses is needed.

The port is shared. On a cycle with a write, any read request is dropped. A read returns its data one cycle after the request, and the result holds until the next read that is accepted. When the parameter `SCRUB_ON_READ` is set, a read that hits a stale entry also writes zero into the RAM at that address and makes the entry fresh. The physical contents then match what software sees, and a later clear is not needed for that entry.

Top module: `rmc_fastclr_mem`

## Requirements
- R1: After reset, `rd_data` is 0 and a read of every address returns 0.
- R2: A one-cycle pulse on `clr_all` makes every entry read as 0 from the next cycle onward, until that entry is written again.
- R3: A write of `wr_data` to `addr` is returned by a later read of that address. The read data appears on `rd_data` in the cycle after `rd_en` is sampled.
- R4: A read of an entry whose flag is set returns 0, whatever data the RAM stored there before the flag was set.
- R5: When `clr_all` and `wr_en` are high in the same cycle, the written address keeps the new data and every other address reads as 0.
- R6: `rd_data` changes only after a cycle with `rd_en` high and `wr_en` low. A write has priority on the shared port, so a read requested in the same cycle is dropped and `rd_data` holds its value.
- R7: With `SCRUB_ON_READ` set, a read of a stale entry writes zero into that entry and clears its flag. Later reads of that entry return 0 until it is written.
- R8: A read accepted in the same cycle as `clr_all` returns the entry's value from before the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; sets all stale flags |
| clr_all | input | 1 | Marks every entry stale in one cycle |
| wr_en | input | 1 | Write request; has priority on the port |
| rd_en | input | 1 | Read request; result on `rd_data` next cycle |
| addr | input | ADDR_W | Entry index for the read or the write |
| wr_data | input | DATA_W | Data to store |
| rd_data | output | DATA_W | Read result, zero for stale entries |

## Verification
The hardest cases to reach are the ones where commands collide in a single cycle. These are a write and a clear together, a read and a clear together, and a write that takes the port away from a read. Each case only shows up in the data returned by a later read. The stimulus first fills every address with distinct nonzero data, so a missing mask or a lost write shows as a wrong value. It then issues each collision directly, and follows it with a read sweep of every address that is compared against the reference model on every clock.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_SCRUB = 2'd3
    } port_op_e;

    // Write owns the shared port; a read of a stale entry may also zero it.
    function automatic port_op_e pick_op(input logic we, input logic re,
                                         input logic stale_hit, input logic scrub_en);
        if (we)                            return OP_WRITE;
        if (re && stale_hit && scrub_en)   return OP_SCRUB;
        if (re)                            return OP_READ;
        return OP_IDLE;
    endfunction

endpackage

// File: rtl/rmc_store.sv
module rmc_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] rq
);
    logic [DATA_W-1:0] cells [DEPTH];

    // No reset on the array: this models plain synchronous RAM.
    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wd;
        if (re) rq <= cells[addr];
    end
endmodule

// File: rtl/rmc_stale_flags.sv
module rmc_stale_flags #(
    parameter int DEPTH = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_all,
    input  logic              wr_go,
    input  logic              scrub_go,
    input  logic [ADDR_W-1:0] idx,
    output logic [DEPTH-1:0]  stale_o
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_flag
        logic hit;
        assign hit = (idx == ADDR_W'(i));
        always_ff @(posedge clk) begin
            if (rst)                  stale_o[i] <= 1'b1;
            else if (wr_go && hit)    stale_o[i] <= 1'b0;
            else if (clr_all)         stale_o[i] <= 1'b1;
            else if (scrub_go && hit) stale_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/rmc_fastclr_mem.sv
module rmc_fastclr_mem #(
    parameter int DATA_W        = 16,
    parameter int DEPTH         = 16,
    parameter bit SCRUB_ON_READ = 1'b1,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_all,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    import rmc_pkg::*;

    logic [DEPTH-1:0]  stale_vec;
    logic              stale_here;
    port_op_e          op;
    logic              ram_we, ram_re;
    logic [DATA_W-1:0] ram_wd, ram_q;
    logic              mask_q;

    assign stale_here = stale_vec[addr];
    assign op         = pick_op(wr_en, rd_en, stale_here, SCRUB_ON_READ);
    assign ram_we     = (op == OP_WRITE) || (op == OP_SCRUB);
    assign ram_re     = (op == OP_READ)  || (op == OP_SCRUB);
    assign ram_wd     = (op == OP_WRITE) ? wr_data : '0;

    rmc_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk (clk),
        .we  (ram_we),
        .re  (ram_re),
        .addr(addr),
        .wd  (ram_wd),
        .rq  (ram_q)
    );

    rmc_stale_flags #(.DEPTH(DEPTH)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .clr_all (clr_all),
        .wr_go   (op == OP_WRITE),
        .scrub_go(op == OP_SCRUB),
        .idx     (addr),
        .stale_o (stale_vec)
    );

    // Flag captured alongside the RAM read so the mask aligns with its data.
    always_ff @(posedge clk) begin
        if (rst)         mask_q <= 1'b1;
        else if (ram_re) mask_q <= stale_here;
    end

    assign rd_data = mask_q ? '0 : ram_q;
endmodule

// File: rtl/rmc_fastclr_chk.sv
module rmc_fastclr_chk #(
    parameter int DATA_W        = 16,
    parameter int DEPTH         = 16,
    parameter bit SCRUB_ON_READ = 1'b1,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              clr_all,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [DEPTH-1:0]  stale
);
    // R1
    reset_all_stale_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (&stale));

    // R2
    clear_sets_all_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_all && !wr_en) |=> (&stale));

    // R3
    write_freshens_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !stale[$past(addr)]);

    // R4
    stale_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && stale[addr]) |=> (rd_data == '0));

    // R5
    clear_write_mix_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_all && wr_en) |=> ($countones(stale) == DEPTH - 1));

    // R6
    hold_without_read_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && !wr_en) |=> $stable(rd_data));

    // R7
    scrub_freshens_chk: assert property (@(posedge clk) disable iff (rst)
        (SCRUB_ON_READ && rd_en && !wr_en && !clr_all && stale[addr]) |=> !stale[$past(addr)]);
endmodule

bind rmc_fastclr_mem rmc_fastclr_chk #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .SCRUB_ON_READ(SCRUB_ON_READ)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .clr_all(clr_all),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .rd_data(rd_data),
    .stale  (stale_vec)
);

// File: tb/tb_rmc_fastclr_mem.sv
module tb_rmc_fastclr_mem;
    localparam int DW = 16;
    localparam int DEPTH = 16;
    localparam int AW = $clog2(DEPTH);
    localparam bit SCRUB = 1'b1;

    logic clk = 1'b0, rst = 1'b1, clr_all = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    // Reference model state
    int unsigned mem_m [DEPTH];
    bit          stale_m [DEPTH];
    int unsigned exp_rd = 0;

    always #5 clk = ~clk;

    rmc_fastclr_mem #(.DATA_W(DW), .DEPTH(DEPTH), .SCRUB_ON_READ(SCRUB)) dut (
        .clk(clk), .rst(rst), .clr_all(clr_all), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic check(input string tag);
        checks++;
        if (rd_data !== DW'(exp_rd)) begin
            failures++;
            $display("FAIL %s rd_data actual=%0h expected=%0h", tag, rd_data, exp_rd);
        end
    endtask

    // One clock: drive at negedge, advance model at posedge, compare at next negedge.
    task automatic cyc(input bit c, input bit we, input bit re, input int a,
                       input int unsigned d, input string tag);
        clr_all = c; wr_en = we; rd_en = re; addr = AW'(a); wr_data = DW'(d);
        @(posedge clk);
        if (re && !we) begin
            exp_rd = stale_m[a] ? 0 : mem_m[a];
            if (SCRUB && stale_m[a]) begin mem_m[a] = 0; stale_m[a] = 0; end
        end
        if (c) for (int i = 0; i < DEPTH; i++) stale_m[i] = 1;
        if (we) begin mem_m[a] = d & 32'hFFFF; stale_m[a] = 0; end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin mem_m[i] = 0; stale_m[i] = 1; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset value");
        for (int i = 0; i < DEPTH; i++) cyc(0, 0, 1, i, 0, "R1 read after reset");

        // Fill with distinct nonzero data, then read back
        for (int i = 0; i < DEPTH; i++) cyc(0, 1, 0, i, 16'hA000 + i * 37, "R3 write");
        for (int i = 0; i < DEPTH; i++) cyc(0, 0, 1, i, 0, "R3 readback");

        // Read during clear sees old value, then everything reads zero
        cyc(1, 0, 1, 5, 0, "R8 read with clear");
        for (int i = 0; i < DEPTH; i++) cyc(0, 0, 1, i, 0, "R2 read after clear");

        // Refill, clear, read stale entries (RAM still holds data)
        for (int i = 0; i < DEPTH; i++) cyc(0, 1, 0, i, 16'h5100 + i, "R4 refill");
        cyc(1, 0, 0, 0, 0, "R2 clear pulse");
        for (int i = 0; i < DEPTH; i += 3) cyc(0, 0, 1, i, 0, "R4 stale read");
        // Second read of scrubbed entries stays zero
        for (int i = 0; i < DEPTH; i += 3) cyc(0, 0, 1, i, 0, "R7 scrubbed reread");

        // Write and clear together
        for (int i = 0; i < DEPTH; i++) cyc(0, 1, 0, i, 16'h7700 ^ i, "R5 prefill");
        cyc(1, 1, 0, 9, 16'hBEEF, "R5 write with clear");
        for (int i = 0; i < DEPTH; i++) cyc(0, 0, 1, i, 0, "R5 sweep");

        // Port priority and hold
        cyc(0, 0, 1, 9, 0, "R6 setup read");
        cyc(0, 1, 1, 3, 16'h1234, "R6 write drops read");
        cyc(0, 0, 0, 3, 0, "R6 idle hold");
        cyc(1, 0, 0, 3, 0, "R6 clear hold");
        cyc(0, 1, 0, 3, 16'h4321, "R3 rewrite after clear");
        cyc(0, 0, 1, 3, 0, "R3 latency check");
        cyc(0, 0, 1, 4, 0, "R4 neighbour still stale");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(10 * 100000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule